// File: doc/BRIEF.md
# Receive Packet Recorder

This block sits behind a serial link's character decoder. It takes received characters one at a time: data bytes, a normal end-of-packet marker, an error end-of-packet marker, and a separate strobe for a link error. It packs the data bytes into 32-bit words and presents them on a write port for a receive data FIFO. For every packet it also writes one record into a packet-length FIFO. The record holds the packet's byte count and a flag that marks the packet as bad.

The block keeps four sticky status bits. Software clears each bit by writing a one to its position. The block compares the two FIFO fill levels against thresholds that software can program, and it raises an interrupt when the data FIFO gets close to full. It also composes a count word that reports both FIFO levels together.

The FIFOs are outside the block. It sees them only through their write ports, a full flag and their fill levels.

Top module: `rx_pkt_recorder`

## Requirements
- R1: Data characters use `chr_kind_i` = 0. They are packed least significant byte first, so the first byte of a word lands in bits 7:0. A complete word appears on `dwr_data_o` with `dwr_en_o` high in the cycle after its fourth byte is sampled.
- R2: An end marker is `chr_kind_i` = 1 (normal) or 2 (error). When an end marker arrives with one to three bytes pending, the partial word is written with its unused upper bytes set to zero. When no bytes are pending, no extra word is written.
- R3: Every end marker writes exactly one length record on `lwr_data_o`. Bits 15:0 hold the packet's byte count and bit 16 is the error flag. The flag is 0 for a normal end and 1 for an error end. An end marker that follows no data writes a record with a count of zero.
- R4: A link error strobe that arrives during a packet has these effects:
  - Data writes stop at once, and pending bytes are discarded.
  - One length record is written, holding the byte count so far with bit 16 set.
  - A strobe that arrives between packets writes no record.
  - A character presented in the same cycle as the strobe is dropped.
- R5: A word that is due while `dfull_i` is high is not written. The drop sets status bit 1 (overflow) and status bit 0 (receive error). The packet carries on, and its length record counts every byte received, with bit 16 clear.
- R6: `afull_o` is high when the data level is equal to or above the almost-full threshold. Status bit 2 latches that condition. The threshold resets to all ones.
- R7: `pfull_o` is high when the length-FIFO level is equal to or above a 10-bit threshold, which resets to 0x3DF. Status bit 3 latches that condition. A configuration write with `cfg_sel_i` = 0 sets the almost-full threshold; with `cfg_sel_i` = 1 it sets the length-FIFO threshold from the low 10 bits of the data.
- R8: A latched status bit stays set until `clr_i` carries a one in its position. A one in another position leaves it unchanged. A link error strobe also sets status bit 0.
- R9: `irq_o` is high only when status bit 2, `afl_ie_i` and `mie_i` are all set.
- R10: `count_o` reports the length-FIFO level in bits 31:20 and the data-FIFO level in bits 19:0.
- R11: After reset, all write strobes, status bits, `irq_o` and the compare outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chr_vld_i | input | 1 | Character valid |
| chr_kind_i | input | 2 | 0 data, 1 end, 2 error end |
| chr_byte_i | input | 8 | Data byte |
| link_err_i | input | 1 | Link error strobe |
| dfull_i | input | 1 | Data FIFO full |
| dlevel_i | input | 20 | Data FIFO word level |
| plevel_i | input | 12 | Length FIFO entry level |
| cfg_we_i | input | 1 | Threshold write strobe |
| cfg_sel_i | input | 1 | 0 almost-full, 1 length-FIFO threshold |
| cfg_wdata_i | input | 20 | Threshold value |
| clr_i | input | 4 | Write-one-to-clear status strobes |
| afl_ie_i | input | 1 | Almost-full interrupt enable |
| mie_i | input | 1 | Master interrupt enable |
| dwr_en_o | output | 1 | Data FIFO write |
| dwr_data_o | output | 32 | Data FIFO word |
| lwr_en_o | output | 1 | Length FIFO write |
| lwr_data_o | output | 17 | {error, byte count} |
| status_o | output | 4 | Latched status bits |
| afull_o | output | 1 | Live almost-full compare |
| pfull_o | output | 1 | Live length-FIFO threshold compare |
| irq_o | output | 1 | Interrupt |
| count_o | output | 32 | Combined level word |

## Verification
The bench sweeps packet lengths from zero to nine bytes with both kinds of end marker, which covers every lane position. A design that wrote an extra zero word on an aligned end, or shifted the bytes into the wrong lanes, fails on the computed word values.

It also aborts packets with a link error after zero to six bytes. A design that flushed the partial word, or wrote a record for an empty abort, is caught here.

An overflow in the middle of a packet checks that the dropped word is counted and that the packet still ends cleanly. The threshold compares are tested one level either side of the reset values and of programmed values. The interrupt is tested against each combination of its enables.

// File: rtl/rxrec_pkg.sv
package rxrec_pkg;
  typedef enum logic [1:0] {
    CH_DATA = 2'd0,
    CH_EOP  = 2'd1,
    CH_EEP  = 2'd2
  } chr_kind_e;

  localparam int ST_W       = 4;
  localparam int ST_RXERR   = 0;
  localparam int ST_OVF     = 1;
  localparam int ST_AFULL   = 2;
  localparam int ST_PFULL   = 3;
endpackage

// File: rtl/rxrec_packer.sv
module rxrec_packer
  import rxrec_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chr_vld_i,
  input  logic [1:0]       chr_kind_i,
  input  logic [7:0]       chr_byte_i,
  input  logic             link_err_i,
  input  logic             dfull_i,
  output logic             dwr_en_o,
  output logic [DW-1:0]    dwr_data_o,
  output logic             lwr_en_o,
  output logic [CNT_W:0]   lwr_data_o,
  output logic             ovf_o,
  output logic             err_o
);
  localparam int LANES  = DW / 8;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  chr_kind_e            kind;
  logic [LANE_W-1:0]    lane_q;
  logic [DW-1:0]        acc_q;
  logic [DW-1:0]        word_nxt;
  logic [CNT_W-1:0]     cnt_q;
  logic                 in_pkt_q;
  logic                 emit;
  logic [DW-1:0]        emit_word;
  logic                 is_data, is_end;

  assign kind    = chr_kind_e'(chr_kind_i);
  assign is_data = chr_vld_i && !link_err_i && (kind == CH_DATA);
  assign is_end  = chr_vld_i && !link_err_i && (kind == CH_EOP || kind == CH_EEP);

  // merge incoming byte into its lane
  always_comb begin
    word_nxt = acc_q;
    word_nxt[lane_q*8 +: 8] = chr_byte_i;
  end

  // decide whether a word leaves this cycle
  always_comb begin
    emit      = 1'b0;
    emit_word = acc_q;
    if (is_data && lane_q == LAST_LANE) begin
      emit      = 1'b1;
      emit_word = word_nxt;
    end else if (is_end && lane_q != '0) begin
      emit      = 1'b1;
      emit_word = acc_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q     <= '0;
      acc_q      <= '0;
      cnt_q      <= '0;
      in_pkt_q   <= 1'b0;
      dwr_en_o   <= 1'b0;
      dwr_data_o <= '0;
      lwr_en_o   <= 1'b0;
      lwr_data_o <= '0;
      ovf_o      <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      dwr_en_o <= 1'b0;
      lwr_en_o <= 1'b0;
      ovf_o    <= 1'b0;
      err_o    <= link_err_i;
      if (emit) begin
        if (dfull_i) begin
          ovf_o <= 1'b1;
        end else begin
          dwr_en_o   <= 1'b1;
          dwr_data_o <= emit_word;
        end
      end
      if (link_err_i) begin
        if (in_pkt_q) begin
          lwr_en_o   <= 1'b1;
          lwr_data_o <= {1'b1, cnt_q};
        end
        in_pkt_q <= 1'b0;
        cnt_q    <= '0;
        lane_q   <= '0;
        acc_q    <= '0;
      end else if (is_data) begin
        in_pkt_q <= 1'b1;
        cnt_q    <= cnt_q + CNT_W'(1);
        if (lane_q == LAST_LANE) begin
          lane_q <= '0;
          acc_q  <= '0;
        end else begin
          lane_q <= lane_q + LANE_W'(1);
          acc_q  <= word_nxt;
        end
      end else if (is_end) begin
        lwr_en_o   <= 1'b1;
        lwr_data_o <= {(kind == CH_EEP), cnt_q};
        in_pkt_q   <= 1'b0;
        cnt_q      <= '0;
        lane_q     <= '0;
        acc_q      <= '0;
      end
    end
  end

  // R4: abort stops data at once and records a bad entry
  p_abort_no_data_r4: assert property (@(posedge clk) disable iff (rst)
    link_err_i |=> !dwr_en_o);
  p_abort_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (link_err_i && in_pkt_q) |=> (lwr_en_o && lwr_data_o[CNT_W]));
  // R5: nothing is written into a full FIFO
  p_no_write_full_r5: assert property (@(posedge clk) disable iff (rst)
    (chr_vld_i && dfull_i && !link_err_i) |=> !dwr_en_o);
  // R3: every end marker writes one record
  p_end_record_r3: assert property (@(posedge clk) disable iff (rst)
    is_end |=> lwr_en_o);
endmodule

// File: rtl/rxrec_thresh.sv
module rxrec_thresh #(
  parameter int DLVL_W = 20,
  parameter int PLVL_W = 12,
  parameter int PTHR_W = 10,
  parameter logic [PTHR_W-1:0] PTHR_RST = 10'h3DF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DLVL_W-1:0]        dlevel_i,
  input  logic [PLVL_W-1:0]        plevel_i,
  input  logic                     cfg_we_i,
  input  logic                     cfg_sel_i,
  input  logic [DLVL_W-1:0]        cfg_wdata_i,
  output logic                     afull_o,
  output logic                     pfull_o,
  output logic [PLVL_W+DLVL_W-1:0] count_o
);
  logic [DLVL_W-1:0] afl_thr_q;
  logic [PTHR_W-1:0] pkt_thr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      afl_thr_q <= '1;
      pkt_thr_q <= PTHR_RST;
    end else if (cfg_we_i) begin
      if (cfg_sel_i) pkt_thr_q <= cfg_wdata_i[PTHR_W-1:0];
      else           afl_thr_q <= cfg_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      afull_o <= 1'b0;
      pfull_o <= 1'b0;
      count_o <= '0;
    end else begin
      afull_o <= (dlevel_i >= afl_thr_q);
      pfull_o <= ({{(PLVL_W > PTHR_W ? 0 : PTHR_W-PLVL_W){1'b0}}, plevel_i}
                  >= {{(PLVL_W > PTHR_W ? PLVL_W-PTHR_W : 0){1'b0}}, pkt_thr_q});
      count_o <= {plevel_i, dlevel_i};
    end
  end
endmodule

// File: rtl/rxrec_status.sv
module rxrec_status
  import rxrec_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            err_i,
  input  logic            ovf_i,
  input  logic            afull_i,
  input  logic            pfull_i,
  input  logic [ST_W-1:0] clr_i,
  input  logic            afl_ie_i,
  input  logic            mie_i,
  output logic [ST_W-1:0] status_o,
  output logic            irq_o
);
  logic [ST_W-1:0] set_v;

  always_comb begin
    set_v           = '0;
    set_v[ST_RXERR] = err_i | ovf_i;
    set_v[ST_OVF]   = ovf_i;
    set_v[ST_AFULL] = afull_i;
    set_v[ST_PFULL] = pfull_i;
  end

  // set wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_o <= (status_o & ~clr_i) | set_v;
      irq_o    <= status_o[ST_AFULL] & afl_ie_i & mie_i;
    end
  end

  generate
    for (genvar i = 0; i < ST_W; i++) begin : g_hold
      // R8: a latched bit is only dropped by a one in its clear position
      p_latch_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (status_o[i] && !clr_i[i]) |=> status_o[i]);
    end
  endgenerate

  // R9: interrupt requires latched almost-full and both enables
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(status_o[ST_AFULL] && afl_ie_i && mie_i));
  // R6: live almost-full latches one cycle later
  p_afull_latch_r6: assert property (@(posedge clk) disable iff (rst)
    afull_i |=> status_o[ST_AFULL]);
endmodule

// File: rtl/rx_pkt_recorder.sv
module rx_pkt_recorder
  import rxrec_pkg::*;
#(
  parameter int DW     = 32,
  parameter int CNT_W  = 16,
  parameter int DLVL_W = 20,
  parameter int PLVL_W = 12,
  parameter int PTHR_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     chr_vld_i,
  input  logic [1:0]               chr_kind_i,
  input  logic [7:0]               chr_byte_i,
  input  logic                     link_err_i,
  input  logic                     dfull_i,
  input  logic [DLVL_W-1:0]        dlevel_i,
  input  logic [PLVL_W-1:0]        plevel_i,
  input  logic                     cfg_we_i,
  input  logic                     cfg_sel_i,
  input  logic [DLVL_W-1:0]        cfg_wdata_i,
  input  logic [ST_W-1:0]          clr_i,
  input  logic                     afl_ie_i,
  input  logic                     mie_i,
  output logic                     dwr_en_o,
  output logic [DW-1:0]            dwr_data_o,
  output logic                     lwr_en_o,
  output logic [CNT_W:0]           lwr_data_o,
  output logic [ST_W-1:0]          status_o,
  output logic                     afull_o,
  output logic                     pfull_o,
  output logic                     irq_o,
  output logic [PLVL_W+DLVL_W-1:0] count_o
);
  logic ovf_w, err_w;

  rxrec_packer #(.DW(DW), .CNT_W(CNT_W)) u_packer (
    .clk(clk), .rst(rst),
    .chr_vld_i(chr_vld_i), .chr_kind_i(chr_kind_i), .chr_byte_i(chr_byte_i),
    .link_err_i(link_err_i), .dfull_i(dfull_i),
    .dwr_en_o(dwr_en_o), .dwr_data_o(dwr_data_o),
    .lwr_en_o(lwr_en_o), .lwr_data_o(lwr_data_o),
    .ovf_o(ovf_w), .err_o(err_w)
  );

  rxrec_thresh #(.DLVL_W(DLVL_W), .PLVL_W(PLVL_W), .PTHR_W(PTHR_W),
                 .PTHR_RST(PTHR_W'(10'h3DF))) u_thresh (
    .clk(clk), .rst(rst),
    .dlevel_i(dlevel_i), .plevel_i(plevel_i),
    .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
    .afull_o(afull_o), .pfull_o(pfull_o), .count_o(count_o)
  );

  rxrec_status u_status (
    .clk(clk), .rst(rst),
    .err_i(err_w), .ovf_i(ovf_w), .afull_i(afull_o), .pfull_i(pfull_o),
    .clr_i(clr_i), .afl_ie_i(afl_ie_i), .mie_i(mie_i),
    .status_o(status_o), .irq_o(irq_o)
  );
endmodule

// File: tb/rx_pkt_recorder_test.sv
module rx_pkt_recorder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chr_vld_i = 0;
  logic [1:0]  chr_kind_i = 0;
  logic [7:0]  chr_byte_i = 0;
  logic        link_err_i = 0, dfull_i = 0;
  logic [19:0] dlevel_i = 0;
  logic [11:0] plevel_i = 0;
  logic        cfg_we_i = 0, cfg_sel_i = 0;
  logic [19:0] cfg_wdata_i = 0;
  logic [3:0]  clr_i = 0;
  logic        afl_ie_i = 0, mie_i = 0;
  logic        dwr_en_o, lwr_en_o, afull_o, pfull_o, irq_o;
  logic [31:0] dwr_data_o, count_o;
  logic [16:0] lwr_data_o;
  logic [3:0]  status_o;

  int checks = 0, fails = 0;
  logic [31:0] dq [0:255];
  logic [16:0] lq [0:255];
  int dn = 0, ln = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_pkt_recorder uut (.*);

  always @(negedge clk) if (!rst) begin
    if (dwr_en_o) begin dq[dn[7:0]] = dwr_data_o; dn = dn + 1; end
    if (lwr_en_o) begin lq[ln[7:0]] = lwr_data_o; ln = ln + 1; end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bv(int p, int i);
    return 8'(p*37 + i*11 + 5);
  endfunction

  task automatic send(input logic [1:0] k, input logic [7:0] b);
    @(negedge clk); chr_vld_i = 1; chr_kind_i = k; chr_byte_i = b;
    @(negedge clk); chr_vld_i = 0;
  endtask

  task automatic pulse_err();
    @(negedge clk); link_err_i = 1;
    @(negedge clk); link_err_i = 0;
  endtask

  task automatic clear(input logic [3:0] m);
    @(negedge clk); clr_i = m;
    @(negedge clk); clr_i = 0;
  endtask

  task automatic cfg(input logic sel, input logic [19:0] v);
    @(negedge clk); cfg_we_i = 1; cfg_sel_i = sel; cfg_wdata_i = v;
    @(negedge clk); cfg_we_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int d0, l0;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    check({dwr_en_o, lwr_en_o, status_o, irq_o, afull_o, pfull_o} == 0 && count_o == 0,
          "R11 reset outputs", {dwr_en_o, lwr_en_o, status_o, irq_o, afull_o, pfull_o}, 0);

    // R1 R2 R3 sweep of lengths and end kinds
    for (int p = 0; p < 10; p++) begin
      for (int e = 0; e < 2; e++) begin
        d0 = dn; l0 = ln;
        for (int i = 0; i < p; i++) send(2'd0, bv(p*2+e, i));
        send(e ? 2'd2 : 2'd1, 8'h00);
        idle(2);
        check(dn - d0 == (p + 3) / 4, "R2 word count", dn - d0, (p + 3) / 4);
        for (int wi = 0; wi < (p + 3) / 4; wi++) begin
          w = 0;
          for (int j = 0; j < 4; j++)
            if (wi*4 + j < p) w[j*8 +: 8] = bv(p*2+e, wi*4 + j);
          check(dq[(d0 + wi) % 256] == w, "R1 word packing", dq[(d0 + wi) % 256], w);
        end
        check(ln - l0 == 1, "R3 record count", ln - l0, 1);
        check(lq[l0 % 256] == {e[0], 16'(p)}, "R3 record value", lq[l0 % 256], {e[0], 16'(p)});
      end
    end

    // R4 aborts after n bytes
    for (int n = 0; n < 7; n++) begin
      d0 = dn; l0 = ln;
      for (int i = 0; i < n; i++) send(2'd0, bv(50 + n, i));
      pulse_err();
      idle(2);
      check(dn - d0 == n / 4, "R4 abort words", dn - d0, n / 4);
      check(ln - l0 == (n > 0 ? 1 : 0), "R4 abort record count", ln - l0, (n > 0 ? 1 : 0));
      if (n > 0) check(lq[l0 % 256] == {1'b1, 16'(n)}, "R4 abort record", lq[l0 % 256], {1'b1, 16'(n)});
      check(status_o[0] == 1'b1, "R8 link error latches bit0", status_o, 1);
      clear(4'b0010);
      check(status_o[0] == 1'b1, "R8 other clear keeps bit0", status_o, 1);
      clear(4'b0001);
      check(status_o[0] == 1'b0, "R8 clear bit0", status_o, 0);
    end

    // R4 character in the same cycle as the strobe is dropped
    d0 = dn; l0 = ln;
    send(2'd0, 8'h11);
    @(negedge clk); link_err_i = 1; chr_vld_i = 1; chr_kind_i = 2'd1;
    @(negedge clk); link_err_i = 0; chr_vld_i = 0;
    idle(2);
    check(ln - l0 == 1 && lq[l0 % 256] == {1'b1, 16'd1}, "R4 simultaneous char dropped", lq[l0 % 256], {1'b1, 16'd1});
    clear(4'b1111);

    // R5 overflow: first word dropped, packet continues
    d0 = dn; l0 = ln;
    dfull_i = 1;
    for (int i = 0; i < 4; i++) send(2'd0, bv(90, i));
    dfull_i = 0;
    for (int i = 4; i < 8; i++) send(2'd0, bv(90, i));
    send(2'd1, 0);
    idle(3);
    w = {bv(90, 7), bv(90, 6), bv(90, 5), bv(90, 4)};
    check(dn - d0 == 1 && dq[d0 % 256] == w, "R5 dropped word only", dq[d0 % 256], w);
    check(lq[l0 % 256] == {1'b0, 16'd8}, "R5 record after overflow", lq[l0 % 256], {1'b0, 16'd8});
    check(status_o[1:0] == 2'b11, "R5 overflow status", status_o, 3);
    clear(4'b0011);
    check(status_o == 0, "R8 cleared", status_o, 0);

    // R10 count word
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); plevel_i = 12'(k*5 + 3); dlevel_i = 20'(k*1000 + 7);
      @(negedge clk);
      check(count_o == {plevel_i, dlevel_i}, "R10 count word", count_o, {plevel_i, dlevel_i});
    end

    // R6 R7 thresholds at reset
    @(negedge clk); plevel_i = 12'h3DE; dlevel_i = 20'hFFFFE;
    @(negedge clk);
    check(!pfull_o && !afull_o, "R7 below reset thresholds", {pfull_o, afull_o}, 0);
    @(negedge clk); plevel_i = 12'h3DF; dlevel_i = 20'hFFFFF;
    @(negedge clk);
    check(pfull_o && afull_o, "R6 at reset thresholds", {pfull_o, afull_o}, 3);
    idle(1);
    check(status_o[3:2] == 2'b11, "R7 latched thresholds", status_o, 12);
    @(negedge clk); plevel_i = 0; dlevel_i = 0;
    idle(1);
    clear(4'b1100);

    // R6 R7 programmed thresholds, sweep levels around them
    cfg(1'b0, 20'd100);
    cfg(1'b1, 20'h00020);
    for (int lv = 98; lv < 103; lv++) begin
      @(negedge clk); dlevel_i = 20'(lv); plevel_i = 12'(lv - 100 + 32);
      @(negedge clk);
      check(afull_o == (lv >= 100), "R6 afull compare", afull_o, lv >= 100);
      check(pfull_o == (lv >= 100), "R7 pkt compare", pfull_o, lv >= 100);
    end
    @(negedge clk); dlevel_i = 0; plevel_i = 0;
    idle(1);
    check(status_o[2] == 1'b1, "R6 latched after level drop", status_o, 4);

    // R9 interrupt gating
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); afl_ie_i = m[0]; mie_i = m[1];
      idle(1);
      check(irq_o == (m == 3), "R9 irq gating", irq_o, m == 3);
    end
    clear(4'b1111);
    idle(1);
    check(irq_o == 0 && status_o == 0, "R9 irq drops after clear", {irq_o, status_o}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule